// File: doc/BRIEF.md
# Binary64 to Int32 Converter with Saturating and Modular Modes

The block turns an IEEE-754 double-precision operand into a 32-bit signed integer. It always rounds toward zero. The 32-bit result is returned sign-extended to 64 bits. One stage of registers sits between the operand and the result, so a result appears one clock after its operand is presented with a valid strobe.

A mode input chooses what happens to values the 32-bit range cannot hold. In saturating mode, such values clamp to the nearest end of the range. In modular mode, the converter keeps the low 32 bits of the truncated integer, so the value wraps modulo 2^32. Infinities and NaNs give zero in modular mode. Either way, an out-of-range operand raises the invalid flag.

A 5-bit accrued-exception vector goes with every result. Bit 0 is inexact, bit 1 is underflow, bit 2 is overflow, bit 3 is divide-by-zero and bit 4 is invalid. Only bits 0 and 4 can ever be set.

Top module: `f64_to_i32_conv`

## Requirements
- R1: While reset is held, and on the first edge after it, out_valid, out_res and out_flags are all zero.
- R2: An operand accepted with in_valid high produces out_valid high on the next rising edge, with its result. A cycle without in_valid produces out_valid low on the next edge. Results leave in the order their operands arrived.
- R3: out_flags bit 0 means inexact and bit 4 means invalid. Bits 1, 2 and 3 (underflow, overflow, divide-by-zero) are always 0. out_res[63:32] always repeats out_res[31].
- R4: Positive and negative zero give 0 with no flags, in both modes.
- R5: Subnormal operands of either sign, and normal operands with magnitude below 1.0, give 0 with only inexact set (flags 5'h01).
- R6: Finite operands whose truncated value lies in [-2^31, 2^31-1] give that value. Inexact is set exactly when a fractional part was discarded. For example, 1.5 gives 1 with 5'h01, -1.5 gives -1 with 5'h01, and -1.0 gives all ones with no flags.
- R7: Exactly 2^31-1 and exactly -2^31 convert with no flags, in both modes.
- R8: In saturating mode (in_wrap=0), finite values above the range give 0x000000007FFFFFFF and values below give 0xFFFFFFFF80000000. Both set only invalid (5'h10).
- R9: In saturating mode, NaN of either sign and +Inf give 0x000000007FFFFFFF, and -Inf gives 0xFFFFFFFF80000000. All set only invalid.
- R10: In modular mode (in_wrap=1), out-of-range finite values give the low 32 bits of the truncated integer, sign-extended, with only invalid set and never inexact. For example, 2^31 gives -2^31, and -2^31-1 gives 2^31-1.
- R11: In modular mode, NaN and both infinities give 0 with only invalid set.
- R12: In modular mode, operands with an unbiased exponent of 84 or more give 0 with only invalid set.
- R13: Inexact and invalid are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Binary64 operand |
| in_wrap | input | 1 | 1 selects modular mode, 0 selects saturating mode |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 64 | Int32 result, sign-extended to 64 bits |
| out_flags | output | 5 | Exception flags: bit 0 inexact, bit 4 invalid |

## Verification
The converter has no parameters. The field widths of the binary64 format are fixed inside it, so the bench builds the only configuration there is. That configuration reaches every biased exponent from 0 to 2047. The bench uses this to cover subnormals, the step at exponent 31 where only -2^31 stays in range, and exponents near 81 where modular mode still keeps nonzero low bits. It also covers exponents far past 84, where the wrapped value must be zero. Operands go back to back with an idle gap between them, so the bench exercises the one-cycle latency and the in-order delivery of results in both modes.

// File: rtl/f64_to_i32_conv.sv
module f64_to_i32_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic        in_wrap,
  output logic        out_valid,
  output logic [63:0] out_res,
  output logic [4:0]  out_flags
);
  localparam int MAN_W = 52;
  localparam int EXP_W = 11;
  localparam int RES_W = 32;
  localparam logic [EXP_W-1:0] BIAS   = 11'd1023;
  localparam logic [EXP_W-1:0] MAN_SH = 11'd52;
  localparam logic [4:0] F_NX = 5'h01;
  localparam logic [4:0] F_NV = 5'h10;
  localparam logic [RES_W-1:0] POS_LIM = 32'h7FFF_FFFF;
  localparam logic [RES_W-1:0] NEG_LIM = 32'h8000_0000;

  logic             sgn;
  logic [EXP_W-1:0] bexp;
  logic [MAN_W-1:0] man;
  assign sgn  = in_op[63];
  assign bexp = in_op[62:MAN_W];
  assign man  = in_op[MAN_W-1:0];

  logic is_special, is_nan, is_tiny, below_one;
  assign is_special = (bexp == '1);
  assign is_nan     = is_special && (man != '0);
  assign is_tiny    = (bexp == '0);
  assign below_one  = (bexp < BIAS);

  logic [EXP_W-1:0] uexp;
  logic [MAN_W:0]   sig;
  assign uexp = bexp - BIAS;
  assign sig  = {1'b1, man};

  logic [RES_W-1:0] mag;
  logic             lost;
  logic [MAN_W:0]   drop_mask;
  always_comb begin
    drop_mask = '0;
    if (uexp <= MAN_SH) begin
      mag       = RES_W'(sig >> (MAN_SH - uexp));
      drop_mask = ~({(MAN_W+1){1'b1}} << (MAN_SH - uexp));
    end else begin
      mag = RES_W'(sig << (uexp - MAN_SH));
    end
    lost = |(sig & drop_mask);
  end

  logic             fits;
  logic [RES_W-1:0] wrapped;
  assign fits    = (uexp < 11'd31) || (uexp == 11'd31 && sgn && mag == NEG_LIM);
  assign wrapped = sgn ? (~mag + 1'b1) : mag;

  logic [RES_W-1:0] res_d;
  logic [4:0]       flg_d;
  always_comb begin
    res_d = '0;
    flg_d = '0;
    if (is_special) begin
      flg_d = F_NV;
      if (!in_wrap) res_d = (sgn && !is_nan) ? NEG_LIM : POS_LIM;
    end else if (is_tiny) begin
      flg_d = (man != '0) ? F_NX : 5'h00;
    end else if (below_one) begin
      flg_d = F_NX;
    end else if (fits) begin
      res_d = wrapped;
      flg_d = lost ? F_NX : 5'h00;
    end else begin
      flg_d = F_NV;
      res_d = in_wrap ? wrapped : (sgn ? NEG_LIM : POS_LIM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res   <= {{(64-RES_W){res_d[RES_W-1]}}, res_d};
        out_flags <= flg_d;
      end
    end
  end
endmodule

module f64_to_i32_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_op,
  input logic        in_wrap,
  input logic        out_valid,
  input logic [63:0] out_res,
  input logic [4:0]  out_flags
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  unused_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[3:1] == 3'b000);
  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_res[63:32] == {32{out_res[31]}});
  // R13
  nx_nv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_flags[0] && out_flags[4]));
  // R4
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[62:0] == 63'd0) |=> (out_res == 64'd0 && out_flags == 5'h00));
  // R11
  wrap_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wrap && in_op[62:52] == 11'h7FF) |=> (out_res == 64'd0 && out_flags == 5'h10));
  // R5
  tiny_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[62:52] < 11'd1023 && in_op[62:0] != 63'd0) |=> (out_res == 64'd0 && out_flags == 5'h01));
endmodule

bind f64_to_i32_conv f64_to_i32_conv_chk chk (.*);

// File: tb/f64_to_i32_conv_test.sv
module f64_to_i32_conv_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        in_wrap = 1'b0;
  logic        out_valid;
  logic [63:0] out_res;
  logic [4:0]  out_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [4:0]  NX = 5'h01;
  localparam logic [4:0]  NV = 5'h10;
  localparam logic [63:0] PMAX = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] NMIN = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;

  logic [68:0] exp_q[$];
  string       tag_q[$];

  f64_to_i32_conv uut (.*);

  always #5 clk = ~clk;

  task automatic drive(input logic [63:0] op, input logic wrap,
                       input logic [63:0] er, input logic [4:0] ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_wrap  = wrap;
    exp_q.push_back({er, ef});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result actual %h expected none", out_res);
      end else begin
        logic [68:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_res !== e[68:5] || out_flags !== e[4:0]) begin
          errors++;
          $display("FAIL %s actual %h/%h expected %h/%h", t, out_res, out_flags, e[68:5], e[4:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_res !== 64'd0 || out_flags !== 5'd0) begin
      errors++;
      $display("FAIL R1 reset actual %b/%h/%h expected 0/0/0", out_valid, out_res, out_flags);
    end
    rst_n = 1'b1;

    drive(64'h0, 1'b0, 64'd0, 5'h00, "R4 +0 sat");
    drive(64'h8000_0000_0000_0000, 1'b1, 64'd0, 5'h00, "R4 -0 wrap");
    drive(64'h0000_0000_0000_0001, 1'b0, 64'd0, NX, "R5 subnormal");
    drive(64'h8000_FFFF_FFFF_FFFF, 1'b1, 64'd0, NX, "R5 neg subnormal");
    drive($realtobits(0.5), 1'b0, 64'd0, NX, "R5 half");
    drive(64'hBFEF_FFFF_FFFF_FFFF, 1'b1, 64'd0, NX, "R5 just above -1");
    idle();
    drive($realtobits(1.0), 1'b0, 64'd1, 5'h00, "R6 one");
    drive($realtobits(-1.0), 1'b1, '1, 5'h00, "R6 minus one");
    drive($realtobits(1.5), 1'b0, 64'd1, NX, "R6 1.5");
    drive($realtobits(-1.5), 1'b1, '1, NX, "R6 -1.5");
    drive($realtobits(-2147483648.5), 1'b0, NMIN, NX, "R6 truncates into range");
    drive($realtobits(2147483647.0), 1'b0, PMAX, 5'h00, "R7 max sat");
    drive($realtobits(2147483647.0), 1'b1, PMAX, 5'h00, "R7 max wrap");
    drive($realtobits(-2147483648.0), 1'b0, NMIN, 5'h00, "R7 min sat");
    drive($realtobits(-2147483648.0), 1'b1, NMIN, 5'h00, "R7 min wrap");
    drive($realtobits(2147483648.0), 1'b0, PMAX, NV, "R8 2^31 sat");
    drive($realtobits(-2147483649.0), 1'b0, NMIN, NV, "R8 -2^31-1 sat");
    drive($realtobits(1.0e300), 1'b0, PMAX, NV, "R8 huge sat");
    drive(QNAN, 1'b0, PMAX, NV, "R9 nan sat");
    drive(64'hFFF8_0000_0000_0001, 1'b0, PMAX, NV, "R9 neg nan sat");
    drive(PINF, 1'b0, PMAX, NV, "R9 +inf sat");
    drive(NINF, 1'b0, NMIN, NV, "R9 -inf sat");
    idle();
    drive($realtobits(2147483648.0), 1'b1, NMIN, NV, "R10 2^31 wrap");
    drive($realtobits(2147483649.0), 1'b1, 64'hFFFF_FFFF_8000_0001, NV, "R10 2^31+1 wrap");
    drive($realtobits(-2147483649.0), 1'b1, PMAX, NV, "R10 -2^31-1 wrap");
    drive($realtobits(-2147483650.0), 1'b1, 64'h0000_0000_7FFF_FFFE, NV, "R10 -2^31-2 wrap");
    drive($realtobits(2147483648.5), 1'b1, NMIN, NV, "R10 R13 fraction dropped silently");
    drive($realtobits(4294967301.0), 1'b1, 64'd5, NV, "R10 2^32+5 wrap");
    drive($realtobits(2.0**81 + 3.0 * 2.0**29), 1'b1, 64'h0000_0000_6000_0000, NV, "R10 exp81 wrap");
    drive(QNAN, 1'b1, 64'd0, NV, "R11 nan wrap");
    drive(PINF, 1'b1, 64'd0, NV, "R11 +inf wrap");
    drive(NINF, 1'b1, 64'd0, NV, "R11 -inf wrap");
    drive($realtobits(2.0**84 + 2.0**33), 1'b1, 64'd0, NV, "R12 exp84 wrap");
    drive($realtobits(-1.0e300), 1'b1, 64'd0, NV, "R12 huge wrap");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 pending actual %0d/%b expected 0/0", exp_q.size(), out_valid);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule